// File: doc/BRIEF.md
# Signed 16-bit Multiply/Divide Unit

This unit serves the extended arithmetic instructions of a 16-bit processor. It takes one 16-bit source operand, the current contents of an even/odd register pair and an operation select. A multiply forms the signed 32-bit product of the operand and the even register. A divide treats the pair as a signed 32-bit dividend and divides it by the operand. The unit returns two 16-bit write-back values, a write enable for each register, and the four condition codes N, Z, V and C.

The unit works sequentially on magnitudes and applies the signs at the end. A one-cycle `start` is accepted only while the unit is idle. `busy` stays high while an iteration runs. `done` then pulses for one cycle, and the results, enables and flags are valid in that cycle. The pair's values and write enables do not reach any register file here. The caller writes them back.

Two divide errors are caught when the request is accepted, with no iteration. The first is a zero divisor. The second is the most negative dividend divided by minus one. A quotient that does not fit in 16 bits is found after the iteration. None of these errors writes a register.

Top module: `muldiv16`

## Requirements
- R1: Multiply (`op_div`=0) sign-extends `operand` and `reg_even`. It forms their 32-bit product. It returns the upper half on `even_val` and the lower half on `odd_val`, with `wr_even` and `wr_odd` both 1.
- R2: After multiply, `cc` = {N,Z,V,C} (bit 3 N, bit 2 Z, bit 1 V, bit 0 C). N is product bit 31. Z is set when the whole 32-bit product is zero. V is 0. C is 1 when the product is above 32767 or below -32768.
- R3: Divide (`op_div`=1) uses {`reg_even`,`reg_odd`} as a signed 32-bit dividend and `operand` as a signed divisor. On success it returns the truncated quotient on `even_val`. It returns the remainder (dividend minus divisor times quotient) on `odd_val`, with both write enables 1.
- R4: After a successful divide, N is quotient bit 15. Z is set when the 16-bit quotient is zero. V and C are 0.
- R5: A divide with `operand` = 0 gives `cc` = 4'b0011 and no write enable. `done` is high in the cycle right after the accepting clock edge.
- R6: A divide of 0x80000000 by 0xFFFF gives `cc` = 4'b0010 and no write enable. `done` is high in the cycle right after the accepting edge.
- R7: A divide whose signed quotient lies outside -32768..32767 gives `cc` = 4'b0010 and no write enable. It still takes the full divide time.
- R8: An accepted multiply raises `busy`. `done` rises 16 clock edges after the accepting edge, and 32 edges after it for a divide that passes the error checks. `done` lasts one cycle and `busy` falls with it.
- R9: `start` while `busy` is 1 is ignored. Operand changes during a run do not alter the result in progress.
- R10: After reset, `busy`, `done`, `wr_even`, `wr_odd` and `cc` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, taken while idle |
| op_div | input | 1 | 0 = multiply, 1 = divide |
| operand | input | 16 | Multiplier or divisor |
| reg_even | input | 16 | Even register contents (multiplicand, dividend high half) |
| reg_odd | input | 16 | Odd register contents (dividend low half) |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle result strobe |
| wr_even | output | 1 | Write `even_val` to the even register |
| wr_odd | output | 1 | Write `odd_val` to the odd register |
| even_val | output | 16 | Product high half or quotient |
| odd_val | output | 16 | Product low half or remainder |
| cc | output | 4 | Condition codes {N,Z,V,C} |

## Verification
The hardest cases are the boundaries of the quotient range. A quotient of exactly -32768 is legal, while +32768 must overflow. The most negative dividend divided by minus one must be trapped early and not iterated. The stimulus reaches these cases with dividends such as 0xFFFF0000 and 0x00010000 divided by 2, and with 0x80000000 divided by 1 and by -1. The bench measures the latency of each case, so an early trap and a full-length overflow are told apart. A second request is injected in the middle of a multiply to show it is dropped.

// File: rtl/muldiv16_pkg.sv
package muldiv16_pkg;
  localparam int CC_N = 3;
  localparam int CC_Z = 2;
  localparam int CC_V = 1;
  localparam int CC_C = 0;
  localparam logic [3:0] CC_ZERO_DIV = 4'b0011;
  localparam logic [3:0] CC_OVF      = 4'b0010;
endpackage

// File: rtl/md_mul_core.sv
module md_mul_core #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic           fin,
  output logic [2*W-1:0] prod_next
);
  localparam int DW = 2 * W;
  localparam int CW = $clog2(W) + 1;

  logic [DW-1:0] acc, mcand, acc_nx;
  logic [W-1:0]  mplier;
  logic [CW-1:0] cnt;
  logic          active;

  always_comb begin
    acc_nx    = acc + (mplier[0] ? mcand : '0);
    fin       = active && (cnt == CW'(W - 1));
    prod_next = acc_nx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      acc    <= '0;
      mcand  <= '0;
      mplier <= '0;
    end else if (load) begin
      active <= 1'b1;
      cnt    <= '0;
      acc    <= '0;
      mcand  <= {{W{1'b0}}, a};
      mplier <= b;
    end else if (active) begin
      acc    <= acc_nx;
      mcand  <= mcand << 1;
      mplier <= mplier >> 1;
      cnt    <= cnt + 1'b1;
      if (fin) active <= 1'b0;
    end
  end
endmodule

// File: rtl/md_div_core.sv
module md_div_core #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [2*W-1:0] dvd,
  input  logic [W-1:0]   dvs,
  output logic           fin,
  output logic [2*W-1:0] quo_next,
  output logic [W-1:0]   rem_next
);
  localparam int DW = 2 * W;
  localparam int CW = $clog2(DW) + 1;

  logic [W-1:0]  rem, dvs_q;
  logic [DW-1:0] quo;
  logic [W:0]    shifted, diff;
  logic          ge;
  logic [CW-1:0] cnt;
  logic          active;

  always_comb begin
    shifted  = {rem, quo[DW-1]};
    diff     = shifted - {1'b0, dvs_q};
    ge       = !diff[W];
    rem_next = ge ? diff[W-1:0] : shifted[W-1:0];
    quo_next = {quo[DW-2:0], ge};
    fin      = active && (cnt == CW'(DW - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      rem    <= '0;
      quo    <= '0;
      dvs_q  <= '0;
    end else if (load) begin
      active <= 1'b1;
      cnt    <= '0;
      rem    <= '0;
      quo    <= dvd;
      dvs_q  <= dvs;
    end else if (active) begin
      rem <= rem_next;
      quo <= quo_next;
      cnt <= cnt + 1'b1;
      if (fin) active <= 1'b0;
    end
  end
endmodule

// File: rtl/muldiv16.sv
module muldiv16
  import muldiv16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         op_div,
  input  logic [W-1:0] operand,
  input  logic [W-1:0] reg_even,
  input  logic [W-1:0] reg_odd,
  output logic         busy,
  output logic         done,
  output logic         wr_even,
  output logic         wr_odd,
  output logic [W-1:0] even_val,
  output logic [W-1:0] odd_val,
  output logic [3:0]   cc
);
  localparam int DW = 2 * W;
  localparam logic [DW-1:0] Q_LIM   = DW'(1) << (W - 1);
  localparam logic [DW-1:0] DVD_MIN = DW'(1) << (DW - 1);

  logic          accept, div_zero, div_min, mul_go, div_go;
  logic [DW-1:0] dividend, d_mag;
  logic [W-1:0]  s_mag, e_mag;
  logic          neg_res, rem_neg;
  logic          fin_m, fin_d;
  logic [DW-1:0] pmag, qmag, prod;
  logic [W-1:0]  rmag, qv, rv;
  logic          mul_c, q_ok;

  always_comb begin
    accept   = start && !busy;
    dividend = {reg_even, reg_odd};
    s_mag    = operand[W-1]  ? -operand : operand;
    e_mag    = reg_even[W-1] ? -reg_even : reg_even;
    d_mag    = reg_even[W-1] ? -dividend : dividend;
    div_zero = (operand == '0);
    div_min  = (dividend == DVD_MIN) && (operand == '1);
    mul_go   = accept && !op_div;
    div_go   = accept && op_div && !div_zero && !div_min;
  end

  md_mul_core #(.W(W)) u_mul (
    .clk(clk), .rst(rst), .load(mul_go), .a(e_mag), .b(s_mag),
    .fin(fin_m), .prod_next(pmag)
  );

  md_div_core #(.W(W)) u_div (
    .clk(clk), .rst(rst), .load(div_go), .dvd(d_mag), .dvs(s_mag),
    .fin(fin_d), .quo_next(qmag), .rem_next(rmag)
  );

  always_comb begin
    prod  = neg_res ? -pmag : pmag;
    mul_c = !((&prod[DW-1:W-1]) || !(|prod[DW-1:W-1]));
    q_ok  = neg_res ? (qmag <= Q_LIM) : (qmag < Q_LIM);
    qv    = neg_res ? -qmag[W-1:0] : qmag[W-1:0];
    rv    = rem_neg ? -rmag : rmag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      wr_even  <= 1'b0;
      wr_odd   <= 1'b0;
      even_val <= '0;
      odd_val  <= '0;
      cc       <= '0;
      neg_res  <= 1'b0;
      rem_neg  <= 1'b0;
    end else begin
      done    <= 1'b0;
      wr_even <= 1'b0;
      wr_odd  <= 1'b0;
      if (accept) begin
        if (op_div && div_zero) begin
          done <= 1'b1;
          cc   <= CC_ZERO_DIV;
        end else if (op_div && div_min) begin
          done <= 1'b1;
          cc   <= CC_OVF;
        end else begin
          busy    <= 1'b1;
          neg_res <= operand[W-1] ^ reg_even[W-1];
          rem_neg <= reg_even[W-1];
        end
      end
      if (fin_m) begin
        busy     <= 1'b0;
        done     <= 1'b1;
        wr_even  <= 1'b1;
        wr_odd   <= 1'b1;
        even_val <= prod[DW-1:W];
        odd_val  <= prod[W-1:0];
        cc[CC_N] <= prod[DW-1];
        cc[CC_Z] <= (prod == '0);
        cc[CC_V] <= 1'b0;
        cc[CC_C] <= mul_c;
      end
      if (fin_d) begin
        busy <= 1'b0;
        done <= 1'b1;
        if (q_ok) begin
          wr_even  <= 1'b1;
          wr_odd   <= 1'b1;
          even_val <= qv;
          odd_val  <= rv;
          cc       <= {qv[W-1], (qv == '0), 1'b0, 1'b0};
        end else begin
          cc <= CC_OVF;
        end
      end
    end
  end
endmodule

// File: rtl/muldiv16_chk.sv
module muldiv16_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         op_div,
  input logic [W-1:0] operand,
  input logic [W-1:0] reg_even,
  input logic [W-1:0] reg_odd,
  input logic         busy,
  input logic         done,
  input logic         wr_even,
  input logic         wr_odd,
  input logic [3:0]   cc
);
  assert_zero_div_R5: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && op_div && operand == '0)
      |=> (done && cc == 4'b0011 && !wr_even && !wr_odd));

  assert_min_div_R6: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && op_div && reg_even == {1'b1, {(W-1){1'b0}}} &&
     reg_odd == '0 && operand == '1)
      |=> (done && cc == 4'b0010 && !wr_even && !wr_odd));

  assert_busy_end_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_mul_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !op_div) |=> busy);

  assert_write_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_even || wr_odd) |-> done);

  assert_write_no_ovf_R4: assert property (@(posedge clk) disable iff (rst)
    wr_even |-> !cc[1]);

  assert_nowrite_ovf_R7: assert property (@(posedge clk) disable iff (rst)
    (done && !wr_even) |-> cc[1]);
endmodule

bind muldiv16 muldiv16_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .op_div(op_div), .operand(operand),
  .reg_even(reg_even), .reg_odd(reg_odd), .busy(busy), .done(done),
  .wr_even(wr_even), .wr_odd(wr_odd), .cc(cc)
);

// File: tb/muldiv16_bench.sv
module muldiv16_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        op_div = 1'b0;
  logic [15:0] operand = '0, reg_even = '0, reg_odd = '0;
  logic        busy, done, wr_even, wr_odd;
  logic [15:0] even_val, odd_val;
  logic [3:0]  cc;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    bit          we;
    logic [15:0] ev;
    logic [15:0] od;
    logic [3:0]  cc;
    string       tag;
  } exp_t;

  exp_t sbq[$];

  always #10 clk = ~clk;

  muldiv16 u_muldiv16 (
    .clk(clk), .rst(rst), .start(start), .op_div(op_div), .operand(operand),
    .reg_even(reg_even), .reg_odd(reg_odd), .busy(busy), .done(done),
    .wr_even(wr_even), .wr_odd(wr_odd), .even_val(even_val),
    .odd_val(odd_val), .cc(cc)
  );

  task automatic model(input bit opd, input logic [15:0] e, o, s,
                       input string tag, output exp_t x, output int lat);
    longint p, dd, dv, q, r;
    x.tag = tag; x.ev = '0; x.od = '0;
    if (!opd) begin
      p = longint'($signed(e)) * longint'($signed(s));
      x.we = 1; x.ev = p[31:16]; x.od = p[15:0];
      x.cc = {p < 0, p == 0, 1'b0, (p > 32767 || p < -32768)};
      lat = 16;
    end else begin
      dd = longint'($signed({e, o}));
      dv = longint'($signed(s));
      if (s == 16'h0) begin
        x.we = 0; x.cc = 4'b0011; lat = 0;
      end else if ({e, o} == 32'h8000_0000 && s == 16'hFFFF) begin
        x.we = 0; x.cc = 4'b0010; lat = 0;
      end else begin
        q = dd / dv;
        r = dd - dv * q;
        lat = 32;
        if (q > 32767 || q < -32768) begin
          x.we = 0; x.cc = 4'b0010;
        end else begin
          x.we = 1; x.ev = q[15:0]; x.od = r[15:0];
          x.cc = {q < 0, q == 0, 1'b0, 1'b0};
        end
      end
    end
  endtask

  task automatic check(input bit ok, input string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s", msg);
    end
  endtask

  // optional interferer: pulse a second start mid-run (R9)
  task automatic run(input bit opd, input logic [15:0] e, o, s,
                     input string tag, input bit interfere);
    exp_t x;
    int lat;
    int n;
    model(opd, e, o, s, tag, x, lat);
    sbq.push_back(x);
    @(negedge clk);
    op_div = opd; reg_even = e; reg_odd = o; operand = s; start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    n = 0;
    while (!done && n < 100) begin
      if (interfere && n == 3) begin
        @(negedge clk);
        op_div = 1'b1; operand = 16'h0; reg_even = 16'h7777; start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
      end else begin
        @(posedge clk);
        #1;
      end
      n++;
    end
    check(n == lat, $sformatf("R8 %s latency actual=%0d expected=%0d", tag, n, lat));
    @(negedge clk);
  endtask

  // monitor: pops expected items as results appear
  always @(posedge clk) begin
    #1;
    if (!rst && done) begin
      if (sbq.size() == 0) begin
        check(0, $sformatf("R9 unexpected done actual=1 expected=0 cc=%b", cc));
      end else begin
        exp_t x;
        x = sbq.pop_front();
        check(wr_even == x.we && wr_odd == x.we && cc == x.cc &&
              (!x.we || (even_val == x.ev && odd_val == x.od)),
              $sformatf("%s actual we=%b/%b ev=%h od=%h cc=%b expected we=%b ev=%h od=%h cc=%b",
                        x.tag, wr_even, wr_odd, even_val, odd_val, cc,
                        x.we, x.ev, x.od, x.cc));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !wr_even && !wr_odd && cc == 4'b0,
          $sformatf("R10 reset actual busy=%b done=%b we=%b%b cc=%b expected all 0",
                    busy, done, wr_even, wr_odd, cc));

    run(0, 16'd3,      16'h0, 16'd5,      "R1 mul 3*5", 0);
    run(0, 16'hFFFF,   16'h0, 16'd1,      "R2 mul -1*1 N", 0);
    run(0, 16'd0,      16'h0, 16'h1234,   "R2 mul zero Z", 0);
    run(0, 16'h8000,   16'h0, 16'h8000,   "R2 mul min*min C", 0);
    run(0, 16'd300,    16'h0, 16'd200,    "R2 mul 60000 C", 0);
    run(0, 16'hFF38,   16'h0, 16'd100,    "R1 mul -200*100", 0);
    run(0, 16'h0080,   16'h0, 16'hFF00,   "R2 mul -32768 no C", 0);
    run(1, 16'h0000,   16'd100, 16'd7,    "R3 div 100/7", 0);
    run(1, 16'hFFFF,   16'hFFF9, 16'd2,   "R3 div -7/2", 0);
    run(1, 16'h0000,   16'd7,  16'hFFFE,  "R3 div 7/-2", 0);
    run(1, 16'h1234,   16'h5678, 16'h7FFF, "R3 div large", 0);
    run(1, 16'hFFFF,   16'h0000, 16'd2,   "R4 div quotient -32768", 0);
    run(1, 16'h0000,   16'd0,  16'd5,     "R4 div zero quotient Z", 0);
    run(1, 16'h1234,   16'h5678, 16'h0000, "R5 div by zero", 0);
    run(1, 16'h8000,   16'h0000, 16'hFFFF, "R6 div min by -1", 0);
    run(1, 16'h0001,   16'h0000, 16'd2,   "R7 div quotient +32768", 0);
    run(1, 16'h8000,   16'h0000, 16'd1,   "R7 div min by 1", 0);
    run(0, 16'd1234,   16'h0,  16'hFFFD,  "R9 mul with start while busy", 1);

    repeat (5) @(posedge clk);
    check(sbq.size() == 0, $sformatf("R8 results pending actual=%0d expected=0", sbq.size()));
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule